// File: doc/BRIEF.md
# Dual-Edge Half-Pixel Video Capture

This block sits at the video input of a display transmitter. It takes 24-bit pixels that arrive over a narrow 12-bit bus as two halves, one half per clock edge. It rebuilds one complete 24-bit pixel per clock cycle. The pixel can be RGB or YCbCr 4:4:4. Horizontal sync, vertical sync and data enable leave the block aligned with the pixel they belong to. A static control bit chooses whether the rising or the falling edge carries the first half. A second static bit turns off the split entirely, so that all 24 lines are captured on the rising edge with the same latency.

The rebuilt pixel leaves the block on `pix_out` in a fixed layout. Bits 23:16 hold red or Cr, bits 15:8 hold green or Y, and bits 7:0 hold blue or Cb. During blanking (data enable low) the pixel is forced to zero, while both sync lines still pass through. The reset is asynchronous and active low. Its release is synchronised to the pixel clock inside the block, so the outputs leave reset two rising edges after `rst_n` goes high. Both control bits are meant to change only while the block is held in reset.

Top module: `dde_pixel_capture`

## Requirements
- R1: While reset is active, `pix_out` is zero and `hsync_out`, `vsync_out` and `de_out` are low.
- R2: With `wide_mode`=0 and `first_on_fall`=0, the first half is sampled on a rising edge and the second half on the following falling edge. From the first half, bus bits 7:0 become pixel bits 7:0 (blue) and bus bits 11:8 become pixel bits 11:8 (low nibble of green). From the second half, bus bits 3:0 become pixel bits 15:12 (high nibble of green) and bus bits 11:4 become pixel bits 23:16 (red).
- R3: With `wide_mode`=0 and `first_on_fall`=1, the first half is sampled on a falling edge and the second half on the next rising edge, with the same bit layout as R2.
- R4: With `wide_mode`=0, `din[23:12]` has no effect on any output.
- R5: In split mode, `hsync_out`, `vsync_out` and `de_out` take the values sampled together with the first half. Values present at the second-half edge are ignored.
- R6: With `wide_mode`=1, `din[23:0]` and the three control inputs are all sampled on the rising edge and reach the outputs unchanged, except as R8 requires.
- R7: In every mode, a pixel and its controls appear on the outputs right after the first rising edge that follows the edge on which its last part was sampled.
- R8: When the output data enable is low, `pix_out` is zero, while `hsync_out` and `vsync_out` still carry their sampled values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock; both edges sample in split mode |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| wide_mode | input | 1 | 1: full 24-bit capture on the rising edge; 0: two 12-bit halves |
| first_on_fall | input | 1 | In split mode, 1 makes the falling edge carry the first half |
| din | input | 24 | Video data lines; only bits 11:0 are used in split mode |
| hsync_in | input | 1 | Horizontal sync |
| vsync_in | input | 1 | Vertical sync |
| de_in | input | 1 | Data enable, high during active video |
| pix_out | output | 24 | Rebuilt pixel {red/Cr, green/Y, blue/Cb} |
| hsync_out | output | 1 | Horizontal sync aligned to `pix_out` |
| vsync_out | output | 1 | Vertical sync aligned to `pix_out` |
| de_out | output | 1 | Data enable aligned to `pix_out` |

## Verification
Two things can land on the same rising edge. One is the output register merging pixel N. The other is the capture of a part of pixel N+1, which is the first half when the first half comes on the rising edge and the second half when it comes on the falling edge. The bench streams pixels back to back, so every cycle holds this overlap. On the second-half edge it drives the inverted control values, and it keeps the unused upper lines busy with garbage. Each output pixel is then compared with the value computed from the two halves that were driven for it. A wrong edge pairing, or controls taken from the wrong half, shows up as a mismatch. The sweep covers every 12-bit first-half value in both edge orders.

// File: rtl/dde_cap_pkg.sv
`timescale 1ns/1ps
package dde_cap_pkg;
  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
  } vctl_t;
endpackage

// File: rtl/dde_rst_sync.sv
`timescale 1ns/1ps
module dde_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q = sync_q[STAGES-1];
endmodule

// File: rtl/dde_edge_capture.sv
`timescale 1ns/1ps
module dde_edge_capture
  import dde_cap_pkg::*;
#(
  parameter int HALF_W = 12,
  localparam int WIDE_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDE_W-1:0] din,
  input  vctl_t             ctl_in,
  output logic [WIDE_W-1:0] rise_data,
  output vctl_t             rise_ctl,
  output logic [HALF_W-1:0] fall_data,
  output vctl_t             fall_ctl,
  output logic [HALF_W-1:0] held_data,
  output vctl_t             held_ctl
);
  logic [WIDE_W-1:0] rise_data_d;
  vctl_t             rise_ctl_d;
  logic [HALF_W-1:0] fall_data_d;
  vctl_t             fall_ctl_d;
  logic [HALF_W-1:0] held_data_d;
  vctl_t             held_ctl_d;

  always_comb begin
    rise_data_d = din;
    rise_ctl_d  = ctl_in;
    fall_data_d = din[HALF_W-1:0];
    fall_ctl_d  = ctl_in;
    held_data_d = fall_data;
    held_ctl_d  = fall_ctl;
  end

  // rising-edge capture, plus a copy of the preceding falling-edge half
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_data <= '0;
      rise_ctl  <= '0;
      held_data <= '0;
      held_ctl  <= '0;
    end else begin
      rise_data <= rise_data_d;
      rise_ctl  <= rise_ctl_d;
      held_data <= held_data_d;
      held_ctl  <= held_ctl_d;
    end
  end

  // falling-edge capture of the lower half of the bus
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_data <= '0;
      fall_ctl  <= '0;
    end else begin
      fall_data <= fall_data_d;
      fall_ctl  <= fall_ctl_d;
    end
  end
endmodule

// File: rtl/dde_pixel_merge.sv
`timescale 1ns/1ps
module dde_pixel_merge
  import dde_cap_pkg::*;
#(
  parameter int COMP_W = 8,
  localparam int HALF_W = (3 * COMP_W) / 2,
  localparam int WIDE_W = 2 * HALF_W,
  localparam int G_LO   = HALF_W - COMP_W,
  localparam int G_HI   = COMP_W - G_LO
) (
  input  logic              wide_mode,
  input  logic              first_on_fall,
  input  logic [WIDE_W-1:0] rise_data,
  input  vctl_t             rise_ctl,
  input  logic [HALF_W-1:0] fall_data,
  input  vctl_t             fall_ctl,
  input  logic [HALF_W-1:0] held_data,
  input  vctl_t             held_ctl,
  output logic [WIDE_W-1:0] pix_d,
  output vctl_t             ctl_d
);
  logic [HALF_W-1:0] first_h;
  logic [HALF_W-1:0] second_h;
  vctl_t             first_c;
  logic [WIDE_W-1:0] split_pix;

  always_comb begin
    if (first_on_fall) begin
      first_h  = held_data;
      first_c  = held_ctl;
      second_h = rise_data[HALF_W-1:0];
    end else begin
      first_h  = rise_data[HALF_W-1:0];
      first_c  = rise_ctl;
      second_h = fall_data;
    end
  end

  // fall_ctl is only needed one cycle later through held_ctl
  logic unused_fall_ctl;
  assign unused_fall_ctl = ^fall_ctl;

  always_comb begin
    split_pix = {second_h[HALF_W-1:G_HI],
                 second_h[G_HI-1:0],
                 first_h[HALF_W-1:COMP_W],
                 first_h[COMP_W-1:0]};
  end

  always_comb begin
    if (wide_mode) begin
      ctl_d = rise_ctl;
      pix_d = rise_data;
    end else begin
      ctl_d = first_c;
      pix_d = split_pix;
    end
    if (!ctl_d.de) pix_d = '0;
  end
endmodule

// File: rtl/dde_out_stage.sv
`timescale 1ns/1ps
module dde_out_stage
  import dde_cap_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] pix_d,
  input  vctl_t            ctl_d,
  output logic [PIX_W-1:0] pix_q,
  output vctl_t            ctl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q <= '0;
      ctl_q <= '0;
    end else begin
      pix_q <= pix_d;
      ctl_q <= ctl_d;
    end
  end
endmodule

// File: rtl/dde_pixel_capture.sv
`timescale 1ns/1ps
module dde_pixel_capture
  import dde_cap_pkg::*;
#(
  parameter int COMP_W = 8,
  localparam int HALF_W = (3 * COMP_W) / 2,
  localparam int PIX_W  = 2 * HALF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide_mode,
  input  logic             first_on_fall,
  input  logic [PIX_W-1:0] din,
  input  logic             hsync_in,
  input  logic             vsync_in,
  input  logic             de_in,
  output logic [PIX_W-1:0] pix_out,
  output logic             hsync_out,
  output logic             vsync_out,
  output logic             de_out
);
  logic              rst_q;
  vctl_t             ctl_in;
  logic [PIX_W-1:0]  rise_data;
  vctl_t             rise_ctl;
  logic [HALF_W-1:0] fall_data;
  vctl_t             fall_ctl;
  logic [HALF_W-1:0] held_data;
  vctl_t             held_ctl;
  logic [PIX_W-1:0]  pix_d;
  vctl_t             ctl_d;
  vctl_t             ctl_q;

  assign ctl_in = '{hs: hsync_in, vs: vsync_in, de: de_in};

  dde_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  dde_edge_capture #(.HALF_W(HALF_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_q),
    .din       (din),
    .ctl_in    (ctl_in),
    .rise_data (rise_data),
    .rise_ctl  (rise_ctl),
    .fall_data (fall_data),
    .fall_ctl  (fall_ctl),
    .held_data (held_data),
    .held_ctl  (held_ctl)
  );

  dde_pixel_merge #(.COMP_W(COMP_W)) u_merge (
    .wide_mode     (wide_mode),
    .first_on_fall (first_on_fall),
    .rise_data     (rise_data),
    .rise_ctl      (rise_ctl),
    .fall_data     (fall_data),
    .fall_ctl      (fall_ctl),
    .held_data     (held_data),
    .held_ctl      (held_ctl),
    .pix_d         (pix_d),
    .ctl_d         (ctl_d)
  );

  dde_out_stage #(.PIX_W(PIX_W)) u_out (
    .clk   (clk),
    .rst_n (rst_q),
    .pix_d (pix_d),
    .ctl_d (ctl_d),
    .pix_q (pix_out),
    .ctl_q (ctl_q)
  );

  assign hsync_out = ctl_q.hs;
  assign vsync_out = ctl_q.vs;
  assign de_out    = ctl_q.de;
endmodule

// File: rtl/dde_pixel_capture_chk.sv
`timescale 1ns/1ps
module dde_pixel_capture_chk #(
  parameter int COMP_W = 8,
  localparam int HALF_W = (3 * COMP_W) / 2,
  localparam int PIX_W  = 2 * HALF_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wide_mode,
  input logic             first_on_fall,
  input logic [PIX_W-1:0] din,
  input logic             hsync_in,
  input logic             vsync_in,
  input logic             de_in,
  input logic [PIX_W-1:0] pix_out,
  input logic             hsync_out,
  input logic             vsync_out,
  input logic             de_out
);
  logic [1:0] age_q;
  logic       armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end
  assign armed = (age_q == 2'd3);

  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (pix_out == '0 && !hsync_out && !vsync_out && !de_out)
        else $error("outputs active during reset");
    end
  end

  // R8
  blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !de_out |-> pix_out == '0);

  // R6
  wide_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && wide_mode && $past(wide_mode) && $past(wide_mode, 2)
      |-> pix_out == ($past(de_in, 2) ? $past(din, 2) : '0));

  // R7
  wide_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && wide_mode && $past(wide_mode) && $past(wide_mode, 2)
      |-> {hsync_out, vsync_out, de_out} == $past({hsync_in, vsync_in, de_in}, 2));

  // R2
  rise_first_blue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !wide_mode && !first_on_fall && $stable(first_on_fall) && $past(!wide_mode)
      |-> pix_out[COMP_W-1:0] == ($past(de_in, 2) ? $past(din[COMP_W-1:0], 2) : '0));

  // R5
  rise_first_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !wide_mode && !first_on_fall && $stable(first_on_fall) && $past(!wide_mode)
      |-> {hsync_out, vsync_out, de_out} == $past({hsync_in, vsync_in, de_in}, 2));
endmodule

bind dde_pixel_capture dde_pixel_capture_chk #(.COMP_W(COMP_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_q),
  .wide_mode     (wide_mode),
  .first_on_fall (first_on_fall),
  .din           (din),
  .hsync_in      (hsync_in),
  .vsync_in      (vsync_in),
  .de_in         (de_in),
  .pix_out       (pix_out),
  .hsync_out     (hsync_out),
  .vsync_out     (vsync_out),
  .de_out        (de_out)
);

// File: tb/dde_pixel_capture_test.sv
`timescale 1ns/1ps
module dde_pixel_capture_test;
  logic        clk;
  logic        rst_n;
  logic        wide_mode;
  logic        first_on_fall;
  logic [23:0] din;
  logic        hsync_in, vsync_in, de_in;
  logic [23:0] pix_out;
  logic        hsync_out, vsync_out, de_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  dde_pixel_capture uut (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .first_on_fall(first_on_fall),
    .din(din), .hsync_in(hsync_in), .vsync_in(vsync_in), .de_in(de_in),
    .pix_out(pix_out), .hsync_out(hsync_out), .vsync_out(vsync_out), .de_out(de_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [11:0] first_of(int i, int s);
    first_of = 12'(i + s * 1021);
  endfunction
  function automatic logic [11:0] second_of(int i, int s);
    second_of = 12'(i * 7 + s * 389 + 5);
  endfunction
  function automatic logic [11:0] junk_of(int i);
    junk_of = 12'((i * 13 + 3) ^ 12'hA5C);
  endfunction
  function automatic logic [2:0] ctl_of(int i);  // {hs, vs, de}
    ctl_of = {1'(i >> 3), 1'(i >> 6), 1'((i % 5) != 0)};
  endfunction
  function automatic logic [23:0] merged(logic [11:0] f, logic [11:0] s);
    merged = {s[11:4], s[3:0], f[11:8], f[7:0]};
  endfunction

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(logic [23:0] d, logic [2:0] c);
    din = d;
    {hsync_in, vsync_in, de_in} = c;
  endtask

  task automatic do_reset(logic wm, logic ff);
    rst_n = 1'b0;
    wide_mode = wm;
    first_on_fall = ff;
    drive('0, 3'b000);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: quiet outputs while reset is held
    check("R1 pixel", pix_out, '0);
    check("R1 controls", {21'd0, hsync_out, vsync_out, de_out}, '0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  // Streams n pixels back to back and checks each one a cycle after completion.
  task automatic stream(logic wm, logic ff, int n, int s);
    logic [23:0] exp;
    logic [2:0]  c;
    do_reset(wm, ff);
    for (int k = -1; k <= n; k++) begin
      @(posedge clk); #2;
      if (!wm && !ff) begin
        if (k >= 0 && k < n) drive({junk_of(k), second_of(k, s)}, ~ctl_of(k));
        else drive('0, 3'b000);
      end else if (!wm && ff) begin
        if (k + 1 < n) drive({junk_of(k + 1), first_of(k + 1, s)}, ctl_of(k + 1));
        else drive('0, 3'b000);
      end
      @(negedge clk); #2;
      if (k >= 1) begin
        c = ctl_of(k - 1);
        if (wm) exp = {second_of(k - 1, s), first_of(k - 1, s)};
        else    exp = merged(first_of(k - 1, s), second_of(k - 1, s));
        if (!c[0]) exp = '0;
        if (wm)
          check(c[0] ? "R6 R7 wide pixel" : "R8 wide blank", pix_out, exp);
        else if (ff)
          check(c[0] ? "R3 R4 R7 fall-first pixel" : "R8 fall-first blank", pix_out, exp);
        else
          check(c[0] ? "R2 R4 R7 rise-first pixel" : "R8 rise-first blank", pix_out, exp);
        check(wm ? "R6 R7 controls" : "R5 R8 controls",
              {21'd0, hsync_out, vsync_out, de_out}, {21'd0, c});
      end
      if (!wm && !ff) begin
        if (k + 1 < n) drive({junk_of(k + 1), first_of(k + 1, s)}, ctl_of(k + 1));
        else drive('0, 3'b000);
      end else if (!wm && ff) begin
        if (k + 1 < n) drive({junk_of(k + 1), second_of(k + 1, s)}, ~ctl_of(k + 1));
        else drive('0, 3'b000);
      end else begin
        if (k + 1 < n) drive({second_of(k + 1, s), first_of(k + 1, s)}, ctl_of(k + 1));
        else drive('0, 3'b000);
      end
    end
  endtask

  initial begin
    rst_n = 1'b0;
    wide_mode = 1'b0;
    first_on_fall = 1'b0;
    drive('0, 3'b000);
    stream(1'b0, 1'b0, 4096, 0);
    stream(1'b0, 1'b1, 4096, 1);
    stream(1'b1, 1'b0, 2048, 2);
    stream(1'b0, 1'b0, 64, 3);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule